// File: doc/BRIEF.md
# Framed Hit Packet Serializer

This block turns a stream of pixel hits into framed packets for a fast serial link. Each hit is a time stamp, a column address and a row address, one byte each. A show-ahead hit FIFO supplies the hits. A frame strobe marks the end of each coarse-time frame. For every accepted strobe the block sends one packet of 8-bit symbols. Each symbol carries a control-character flag, so the stream can go straight into an 8b/10b encoder that drives a link of up to 1.25 Gbit/s.

A packet has the following parts, in order:
- an alignment control character;
- three header bytes: coarse time, frame number and hit count;
- three bytes per hit;
- an end-of-packet control character;
- a 16-bit CRC.

A filler byte is sent whenever no packet is in flight. A strobe that arrives during a packet is held, and its packet follows directly after the CRC.

The block is controlled by one state machine with these states: `ST_IDLE`, `ST_ALIGN`, `ST_TIME`, `ST_FRAME`, `ST_COUNT`, `ST_HIT`, `ST_EOP`, `ST_CRC_HI` and `ST_CRC_LO`. Its transitions are:
- `ST_IDLE`→`ST_ALIGN` on a strobe.
- `ST_ALIGN`→`ST_TIME`→`ST_FRAME`→`ST_COUNT`, one state per cycle.
- `ST_COUNT`→`ST_EOP` when the hit count is zero, otherwise `ST_COUNT`→`ST_HIT`.
- `ST_HIT` loops on itself for three bytes per hit. After the row byte of the last hit it goes to `ST_EOP`.
- `ST_EOP`→`ST_CRC_HI`→`ST_CRC_LO`.
- `ST_CRC_LO`→`ST_ALIGN` when a strobe is held or present, otherwise `ST_CRC_LO`→`ST_IDLE`.

Top module: `hit_framer`

## Requirements
- R1: While reset is held and after its release with no strobe, `sym_data` is the filler byte (default 0xB5), `sym_is_k` is 0 and `fifo_pop` is 0.
- R2: Between packets the block emits the filler byte as a data character (`sym_is_k` = 0) on every cycle.
- R3: A strobe sampled in `ST_IDLE` puts the alignment character 0xBC with `sym_is_k` = 1 on the output in the next cycle.
- R4: The alignment character is followed by three data bytes, in this order:
  - the coarse time that was present with the strobe;
  - the frame number, which is 0 for the first packet after reset and rises by 1 (mod 256) with each packet;
  - the hit count.
- R5: The hit count is the FIFO level when the packet starts, limited to `MAX_HITS` (default 32). Hits beyond the limit stay in the FIFO for the next packet.
- R6: Each hit is sent as three data bytes: time stamp (`fifo_head[23:16]`), then column (`fifo_head[15:8]`), then row (`fifo_head[7:0]`). `fifo_pop` is asserted once per hit, in the row-byte cycle.
- R7: The end-of-packet character 0x1C with `sym_is_k` = 1 follows the last row byte, or follows the count byte directly when the count is 0.
- R8: After the end-of-packet character come two data bytes, high byte first. They hold the CRC-16 (polynomial 0x1021, seed 0xFFFF, MSB-first, no reflection) over every byte from the coarse time through the last hit byte.
- R9: A strobe sampled during a packet is held. The alignment character of the next packet follows the CRC low byte with no filler in between. Further strobes before that packet starts merge into the held one.
- R10: `sym_is_k` is 1 only for the alignment and end-of-packet characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | End-of-frame pulse, requests a packet |
| coarse_time | input | 8 | Coarse time of the frame, taken with the strobe |
| fifo_level | input | LVL_W | Number of hits held in the FIFO |
| fifo_head | input | 24 | Hit at the FIFO head: {time stamp, column, row} |
| fifo_pop | output | 1 | Removes the head hit from the FIFO |
| sym_data | output | 8 | Output symbol byte |
| sym_is_k | output | 1 | Output symbol is a control character |

## Verification
The assertions assume that the FIFO level falls only through `fifo_pop` and that the head word holds still until it is popped. The pop check also relies on the level never dropping under the hit count latched at packet start. The bench FIFO model removes entries only on `fifo_pop`. The bench pushes hits only while no packet is running, so the latched count always stays covered by the level. Random hit bursts are kept small enough that the FIFO model never wraps.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ALIGN, ST_TIME, ST_FRAME, ST_COUNT,
        ST_HIT, ST_EOP, ST_CRC_HI, ST_CRC_LO
    } pkt_state_e;

    localparam logic [7:0]  SYM_ALIGN = 8'hBC;
    localparam logic [7:0]  SYM_EOP   = 8'h1C;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;

    function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16
    import pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc_byte(crc, din);
        end
    end

endmodule

// File: rtl/hit_budget.sv
module hit_budget #(
    parameter int LVL_W    = 7,
    parameter int MAX_HITS = 32,
    parameter int CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LVL_W-1:0] level,
    input  logic             pop,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] remaining
);

    logic [CNT_W-1:0] capped;

    always_comb begin
        if (int'(level) > MAX_HITS) capped = CNT_W'(MAX_HITS);
        else                        capped = CNT_W'(level);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            remaining <= '0;
        end else if (load) begin
            count     <= capped;
            remaining <= capped;
        end else if (pop) begin
            remaining <= remaining - 1'b1;
        end
    end

    // R5
    budget_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (remaining != '0));

    // R5
    budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (int'(count) <= MAX_HITS));

endmodule

// File: rtl/hit_framer.sv
module hit_framer
    import pkt_pkg::*;
#(
    parameter int          LVL_W    = 7,
    parameter int          MAX_HITS = 32,
    parameter logic [7:0]  IDLE_SYM = 8'hB5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic [7:0]       coarse_time,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [23:0]      fifo_head,
    output logic             fifo_pop,
    output logic [7:0]       sym_data,
    output logic             sym_is_k
);

    localparam int CNT_W = $clog2(MAX_HITS + 1);

    pkt_state_e       state, state_nx;
    logic [1:0]       byte_idx;
    logic             held;
    logic [7:0]       ct_next, ct_cur, frame_no;
    logic [CNT_W-1:0] hit_count, hits_left;
    logic [15:0]      crc_val;
    logic             start, crc_en;

    assign start = (state == ST_IDLE && frame_strobe) ||
                   (state == ST_CRC_LO && (held || frame_strobe));
    assign crc_en = (state == ST_TIME) || (state == ST_FRAME) ||
                    (state == ST_COUNT) || (state == ST_HIT);

    hit_budget #(.LVL_W(LVL_W), .MAX_HITS(MAX_HITS), .CNT_W(CNT_W)) u_budget (
        .clk(clk), .rst_n(rst_n), .load(start), .level(fifo_level),
        .pop(fifo_pop), .count(hit_count), .remaining(hits_left)
    );

    pkt_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clear(start), .en(crc_en),
        .din(sym_data), .crc(crc_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (frame_strobe) state_nx = ST_ALIGN;
            ST_ALIGN:  state_nx = ST_TIME;
            ST_TIME:   state_nx = ST_FRAME;
            ST_FRAME:  state_nx = ST_COUNT;
            ST_COUNT:  state_nx = (hit_count == '0) ? ST_EOP : ST_HIT;
            ST_HIT:    if (byte_idx == 2'd2 && hits_left == CNT_W'(1)) state_nx = ST_EOP;
            ST_EOP:    state_nx = ST_CRC_HI;
            ST_CRC_HI: state_nx = ST_CRC_LO;
            ST_CRC_LO: state_nx = (held || frame_strobe) ? ST_ALIGN : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
            held     <= 1'b0;
            ct_next  <= '0;
            ct_cur   <= '0;
            frame_no <= '0;
        end else begin
            if (frame_strobe) ct_next <= coarse_time;
            if (start) begin
                held   <= 1'b0;
                ct_cur <= frame_strobe ? coarse_time : ct_next;
            end else if (frame_strobe && state != ST_IDLE) begin
                held <= 1'b1;
            end
            if (state == ST_COUNT)     byte_idx <= '0;
            else if (state == ST_HIT)  byte_idx <= (byte_idx == 2'd2) ? 2'd0 : byte_idx + 2'd1;
            if (state == ST_CRC_LO)    frame_no <= frame_no + 8'd1;
        end
    end

    // outputs
    always_comb begin
        sym_data = IDLE_SYM;
        sym_is_k = 1'b0;
        fifo_pop = 1'b0;
        unique case (state)
            ST_IDLE:   sym_data = IDLE_SYM;
            ST_ALIGN:  begin sym_data = SYM_ALIGN; sym_is_k = 1'b1; end
            ST_TIME:   sym_data = ct_cur;
            ST_FRAME:  sym_data = frame_no;
            ST_COUNT:  sym_data = 8'(hit_count);
            ST_HIT: begin
                case (byte_idx)
                    2'd0:    sym_data = fifo_head[23:16];
                    2'd1:    sym_data = fifo_head[15:8];
                    default: begin sym_data = fifo_head[7:0]; fifo_pop = 1'b1; end
                endcase
            end
            ST_EOP:    begin sym_data = SYM_EOP; sym_is_k = 1'b1; end
            ST_CRC_HI: sym_data = crc_val[15:8];
            ST_CRC_LO: sym_data = crc_val[7:0];
            default:   sym_data = IDLE_SYM;
        endcase
    end

    // R3
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_strobe) |=> (sym_is_k && sym_data == SYM_ALIGN));

    // R9
    held_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRC_LO && held) |=> (state == ST_ALIGN));

    // R10
    kchar_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_is_k |-> (sym_data == SYM_ALIGN || sym_data == SYM_EOP));

    // R6
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_level != '0));

    // R8
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EOP) |=> $stable(crc_val));

endmodule

// File: tb/sim_hit_framer.sv
module sim_hit_framer;

    localparam logic [7:0] IDLE_B = 8'hB5;
    localparam int MAXH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [7:0]  coarse_time = '0;
    logic [6:0]  fifo_level;
    logic [23:0] fifo_head;
    logic        fifo_pop;
    logic [7:0]  sym_data;
    logic        sym_is_k;

    logic [23:0] mem [0:255];
    logic [7:0]  wp = '0, rp = '0, ref_rp = '0;
    logic [7:0]  exp_fn = '0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign fifo_level = 7'(wp - rp);
    assign fifo_head  = mem[rp];

    always @(posedge clk) if (fifo_pop) rp <= rp + 8'd1;

    hit_framer u0 (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .coarse_time(coarse_time),
        .fifo_level(fifo_level), .fifo_head(fifo_head), .fifo_pop(fifo_pop),
        .sym_data(sym_data), .sym_is_k(sym_is_k)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 7; b >= 0; b--) begin
            logic fb = r[15] ^ d[b];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // compare current symbol, then step to next negedge
    task automatic expect_sym(input logic [7:0] d, input logic k, input string req);
        check(sym_data === d && sym_is_k === k, req, {23'd0, sym_is_k, sym_data}, {23'd0, k, d});
        @(negedge clk);
    endtask

    task automatic push(input logic [23:0] h);
        mem[wp] = h;
        wp = wp + 8'd1;
    endtask

    task automatic pulse(input logic [7:0] ct);
        frame_strobe = 1'b1;
        coarse_time  = ct;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    // call at the negedge where the alignment symbol should appear
    task automatic check_packet(input logic [7:0] ct);
        int n = int'(8'(wp - ref_rp));
        logic [15:0] c = 16'hFFFF;
        if (n > MAXH) n = MAXH;
        expect_sym(8'hBC, 1'b1, "R3");
        expect_sym(ct, 1'b0, "R4 time");   c = ref_crc(c, ct);
        expect_sym(exp_fn, 1'b0, "R4 frame"); c = ref_crc(c, exp_fn);
        expect_sym(8'(n), 1'b0, "R5 count"); c = ref_crc(c, 8'(n));
        for (int i = 0; i < n; i++) begin
            logic [23:0] h = mem[ref_rp];
            expect_sym(h[23:16], 1'b0, "R6 ts");  c = ref_crc(c, h[23:16]);
            expect_sym(h[15:8],  1'b0, "R6 col"); c = ref_crc(c, h[15:8]);
            expect_sym(h[7:0],   1'b0, "R6 row"); c = ref_crc(c, h[7:0]);
            ref_rp = ref_rp + 8'd1;
        end
        expect_sym(8'h1C, 1'b1, "R7");
        expect_sym(c[15:8], 1'b0, "R8 hi");
        check(rp == ref_rp, "R5 leftover", int'(rp), int'(ref_rp));
        expect_sym(c[7:0], 1'b0, "R8 lo");
        exp_fn = exp_fn + 8'd1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1 during reset
        check(sym_data === IDLE_B && sym_is_k === 1'b0 && fifo_pop === 1'b0, "R1", sym_data, IDLE_B);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_data === IDLE_B && sym_is_k === 1'b0 && fifo_pop === 1'b0, "R1", sym_data, IDLE_B);

        // zero hits: EOP right after count (R7)
        pulse(8'h11);
        check_packet(8'h11);
        expect_sym(IDLE_B, 1'b0, "R2");
        expect_sym(IDLE_B, 1'b0, "R2");

        // exactly the limit
        for (int i = 0; i < MAXH; i++) push(24'($urandom));
        pulse(8'h22);
        check_packet(8'h22);
        expect_sym(IDLE_B, 1'b0, "R2");

        // over the limit, excess kept for next packet (R5)
        for (int i = 0; i < 40; i++) push(24'($urandom));
        pulse(8'h33);
        check_packet(8'h33);
        expect_sym(IDLE_B, 1'b0, "R2");
        pulse(8'h34);
        check_packet(8'h34);
        expect_sym(IDLE_B, 1'b0, "R2");

        // held strobe, two strobes merged (R9)
        for (int i = 0; i < 3; i++) push(24'($urandom));
        pulse(8'h40);
        fork
            check_packet(8'h40);
            begin
                repeat (2) @(negedge clk);
                pulse(8'h41);
                @(negedge clk);
                pulse(8'h42);
            end
        join
        check_packet(8'h42);
        expect_sym(IDLE_B, 1'b0, "R9 merged");
        expect_sym(IDLE_B, 1'b0, "R2");

        // random traffic
        for (int it = 0; it < 12; it++) begin
            int nh = int'($urandom_range(0, 34));
            logic [7:0] ct = 8'($urandom);
            for (int i = 0; i < nh; i++) push(24'($urandom));
            repeat (int'($urandom_range(0, 3))) expect_sym(IDLE_B, 1'b0, "R2");
            pulse(ct);
            check_packet(ct);
            expect_sym(IDLE_B, 1'b0, "R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule